// File: doc/BRIEF.md
# Firmware Region Write Guard

This block holds one 8-bit control register that decides whether the boot-firmware region of an SPI flash may be written. Software reaches the register through a small configuration read/write port at a fixed address. Two bits in the register are sticky protections. Once software sets either of them, only a hardware reset can clear it. A third bit is the ordinary write-enable request, and software may set or clear it at any time.

The block drives a registered permit output that the flash controller uses to accept or refuse firmware writes. The permit depends on the write-enable bit, the two sticky protections and an input that tells whether the CPU is in system-management mode. When the lock protection is set, any write that moves write-enable from 0 to 1 also raises a one-cycle system-management interrupt request. The write itself still takes effect, so the management handler can inspect the bit and clear it.

Top module: `fw_guard_ctl`

## Requirements
- R1: After a synchronous reset, the read image is 0x08: write-enable, lock and management protect are 0, the read-config field is 2'b10, and reserved bits 7:6 are 0. `smi_req`, `flash_wr_ok` and `cfg_rdata` are 0.
- R2: The register answers only at address `REG_OFFSET` (default 0xDC). A write to any other address changes nothing. A read of any other address returns 0.
- R3: Bit 5 (management protect) becomes 1 when a 1 is written to it. Writes of 0 to it are ignored until reset.
- R4: Bit 1 (lock) becomes 1 when a 1 is written to it. Writes of 0 to it are ignored until reset.
- R5: Bit 0 (write-enable) takes the written value on every write, whether or not the sticky bits are set.
- R6: `smi_req` is 1 for exactly the one cycle after a register write with bit 0 = 1, when lock was already 1 and write-enable was 0 before that write. It stays 0 when lock is set by that same write, and when write-enable is already 1.
- R7: Bits 3:2 (read-config) are read/write. Bit 4 reads the `top_swap_strap` input through one register stage and ignores writes. Bits 7:6 always read 0.
- R8: `flash_wr_ok` equals wen & (smm | (~protect & ~lock)), one cycle after the register state and `smm_active`. Outside management mode, a write is allowed only with write-enable 1 and both protections 0. In management mode, write-enable 1 is enough.
- R9: A reset clears both sticky bits after they have been set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | ADDR_W | Configuration address |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_wdata | input | 8 | Write data |
| cfg_rd | input | 1 | Read strobe; data appears on the next cycle |
| cfg_rdata | output | 8 | Registered read data |
| smm_active | input | 1 | CPU is in system-management mode |
| top_swap_strap | input | 1 | Strap value reflected in bit 4 |
| smi_req | output | 1 | One-cycle system-management interrupt request |
| flash_wr_ok | output | 1 | Firmware-region write permitted |

## Verification
In a single write that sets write-enable while lock is held, the interrupt request and the register update both happen. The bench issues that write and checks that `smi_req` pulses in the following cycle and that bit 0 reads back as 1. A second collision is one write that sets lock and write-enable together. The bench checks that this write raises no request, because the lock only takes effect after the write. The permit output is then swept over every combination of write-enable, protect, lock and management mode, and compared with the R8 formula.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_WEN   = 0;
  localparam int BIT_LOCK  = 1;
  localparam int BIT_RCFG  = 2;
  localparam int RCFG_W    = 2;
  localparam int BIT_TSWAP = 4;
  localparam int BIT_PROT  = 5;

  // Packed so that field order equals bit position 5..0 of the read image.
  typedef struct packed {
    logic              prot;
    logic              tswap;
    logic [RCFG_W-1:0] rcfg;
    logic              lock;
    logic              wen;
  } fwg_fields_t;

  localparam int FIELD_W = $bits(fwg_fields_t);
  localparam int PAD_W   = REG_W - FIELD_W;
endpackage

// File: rtl/fwg_ctl_reg.sv
module fwg_ctl_reg
  import fwg_pkg::*;
#(
  parameter logic [RCFG_W-1:0] RCFG_RST = 2'b10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              wr_wen,
  input  logic              wr_lock,
  input  logic [RCFG_W-1:0] wr_rcfg,
  input  logic              wr_prot,
  input  logic              strap,
  output fwg_fields_t       fields_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fields_q.wen   <= 1'b0;
      fields_q.lock  <= 1'b0;
      fields_q.rcfg  <= RCFG_RST;
      fields_q.tswap <= 1'b0;
      fields_q.prot  <= 1'b0;
    end else begin
      fields_q.tswap <= strap;
      if (wr_hit) begin
        fields_q.wen  <= wr_wen;
        fields_q.rcfg <= wr_rcfg;
        // sticky: only set, never cleared by software
        fields_q.lock <= fields_q.lock | wr_lock;
        fields_q.prot <= fields_q.prot | wr_prot;
      end
    end
  end
endmodule

// File: rtl/fwg_smi_gen.sv
module fwg_smi_gen (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_wen,
  input  logic lock_q,
  input  logic wen_q,
  output logic smi_req
);
  logic attempt;

  // Uses pre-write state: a lock set by this same write does not count.
  always_comb attempt = wr_hit & wr_wen & lock_q & ~wen_q;

  always_ff @(posedge clk) begin
    if (rst) smi_req <= 1'b0;
    else     smi_req <= attempt;
  end
endmodule

// File: rtl/fwg_permit.sv
module fwg_permit
  import fwg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  fwg_fields_t fields_q,
  input  logic        smm,
  output logic        wr_ok
);
  logic open_path;
  logic smm_path;
  logic unused_fields;

  always_comb begin
    open_path = fields_q.wen & ~fields_q.prot & ~fields_q.lock;
    smm_path  = fields_q.wen & smm;
  end

  assign unused_fields = ^{fields_q.rcfg, fields_q.tswap};

  always_ff @(posedge clk) begin
    if (rst) wr_ok <= 1'b0;
    else     wr_ok <= open_path | smm_path;
  end
endmodule

// File: rtl/fw_guard_ctl.sv
module fw_guard_ctl
  import fwg_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'hDC,
  parameter logic [RCFG_W-1:0] RCFG_RST   = 2'b10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              cfg_rd,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              smm_active,
  input  logic              top_swap_strap,
  output logic              smi_req,
  output logic              flash_wr_ok
);
  logic        addr_hit;
  logic        wr_hit;
  fwg_fields_t fields_q;
  logic [REG_W-1:0] image;
  logic        unused_wbits;

  always_comb begin
    addr_hit = (cfg_addr == REG_OFFSET);
    wr_hit   = cfg_wr & addr_hit;
    image    = {{PAD_W{1'b0}}, fields_q};
  end

  assign unused_wbits = ^{cfg_wdata[REG_W-1:BIT_PROT+1], cfg_wdata[BIT_TSWAP]};

  fwg_ctl_reg #(.RCFG_RST(RCFG_RST)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (wr_hit),
    .wr_wen   (cfg_wdata[BIT_WEN]),
    .wr_lock  (cfg_wdata[BIT_LOCK]),
    .wr_rcfg  (cfg_wdata[BIT_RCFG +: RCFG_W]),
    .wr_prot  (cfg_wdata[BIT_PROT]),
    .strap    (top_swap_strap),
    .fields_q (fields_q)
  );

  fwg_smi_gen u_smi (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (wr_hit),
    .wr_wen  (cfg_wdata[BIT_WEN]),
    .lock_q  (fields_q.lock),
    .wen_q   (fields_q.wen),
    .smi_req (smi_req)
  );

  fwg_permit u_permit (
    .clk      (clk),
    .rst      (rst),
    .fields_q (fields_q),
    .smm      (smm_active),
    .wr_ok    (flash_wr_ok)
  );

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= addr_hit ? image : '0;
  end
endmodule

// File: rtl/fwg_chk.sv
module fwg_chk
  import fwg_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input fwg_fields_t fields_q,
  input logic        smm_active,
  input logic        smi_req,
  input logic        flash_wr_ok
);
  // R3: protect bit never falls without reset
  p_prot_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (fields_q.prot && !rst) |=> fields_q.prot);

  // R4: lock bit never falls without reset
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (fields_q.lock && !rst) |=> fields_q.lock);

  // R6: request is a single-cycle pulse
  p_smi_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    smi_req |=> !smi_req);

  // R6: request only when lock was already held and write-enable rose
  p_smi_cause_r6: assert property (@(posedge clk) disable iff (rst)
    smi_req |-> ($past(fields_q.lock) && !$past(fields_q.wen) && fields_q.wen));

  // R8: permit requires write-enable in the previous cycle
  p_permit_wen_r8: assert property (@(posedge clk) disable iff (rst)
    flash_wr_ok |-> $past(fields_q.wen));

  // R8: outside management mode both protections must have been clear
  p_permit_open_r8: assert property (@(posedge clk) disable iff (rst)
    (flash_wr_ok && !$past(smm_active)) |-> (!$past(fields_q.prot) && !$past(fields_q.lock)));
endmodule

bind fw_guard_ctl fwg_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .fields_q    (fields_q),
  .smm_active  (smm_active),
  .smi_req     (smi_req),
  .flash_wr_ok (flash_wr_ok)
);

// File: tb/fw_guard_ctl_tb.sv
module fw_guard_ctl_tb;
  localparam logic [7:0] OFS = 8'hDC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_addr = '0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       cfg_rd = 1'b0;
  logic [7:0] cfg_rdata;
  logic       smm_active = 1'b0;
  logic       top_swap_strap = 1'b0;
  logic       smi_req;
  logic       flash_wr_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fw_guard_ctl u_dut (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
    .smm_active(smm_active), .top_swap_strap(top_swap_strap),
    .smi_req(smi_req), .flash_wr_ok(flash_wr_ok)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // returns at the negedge after the write edge (register and smi_req updated)
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk); cfg_rd = 1'b0; d = cfg_rdata;
  endtask

  function automatic logic exp_ok(logic w, logic p, logic l, logic s);
    return w & (s | (~p & ~l));
  endfunction

  task automatic t_reset_state();
    logic [7:0] d;
    do_reset();
    chk("R1 smi_req after reset", {7'b0, smi_req}, 8'h00);
    chk("R1 flash_wr_ok after reset", {7'b0, flash_wr_ok}, 8'h00);
    chk("R1 rdata after reset", cfg_rdata, 8'h00);
    rd(OFS, d);
    chk("R1 reset image", d, 8'h08);
  endtask

  task automatic t_offset();
    logic [7:0] d;
    do_reset();
    wr(8'hDD, 8'h23);
    rd(OFS, d);
    chk("R2 miss write ignored", d, 8'h08);
    rd(8'hDD, d);
    chk("R2 miss read returns 0", d, 8'h00);
    @(negedge clk);
    chk("R2 no permit after miss", {7'b0, flash_wr_ok}, 8'h00);
  endtask

  task automatic t_prot_sticky();
    logic [7:0] d;
    do_reset();
    wr(OFS, 8'h28);
    wr(OFS, 8'h08);
    rd(OFS, d);
    chk("R3 protect clear ignored", d, 8'h28);
    do_reset();
    rd(OFS, d);
    chk("R9 reset clears protect", d, 8'h08);
  endtask

  task automatic t_lock_sticky();
    logic [7:0] d;
    do_reset();
    wr(OFS, 8'h0A);
    wr(OFS, 8'h08);
    rd(OFS, d);
    chk("R4 lock clear ignored", d, 8'h0A);
    wr(OFS, 8'h0B);
    wr(OFS, 8'h08);
    rd(OFS, d);
    chk("R5 wen clears while locked", d, 8'h0A);
    do_reset();
    rd(OFS, d);
    chk("R9 reset clears lock", d, 8'h08);
  endtask

  task automatic t_smi();
    logic [7:0] d;
    do_reset();
    wr(OFS, 8'h09);
    chk("R6 no smi when unlocked", {7'b0, smi_req}, 8'h00);
    do_reset();
    wr(OFS, 8'h0B);
    chk("R6 no smi when lock set in same write", {7'b0, smi_req}, 8'h00);
    wr(OFS, 8'h0A);
    chk("R6 no smi on clearing wen", {7'b0, smi_req}, 8'h00);
    wr(OFS, 8'h0B);
    chk("R6 smi on locked enable", {7'b0, smi_req}, 8'h01);
    @(negedge clk);
    chk("R6 smi drops after one cycle", {7'b0, smi_req}, 8'h00);
    rd(OFS, d);
    chk("R5 wen still set after smi", d, 8'h0B);
    wr(OFS, 8'h0B);
    chk("R6 no smi when wen already 1", {7'b0, smi_req}, 8'h00);
  endtask

  task automatic t_fields();
    logic [7:0] d;
    do_reset();
    top_swap_strap = 1'b0;
    wr(OFS, 8'hD4);
    rd(OFS, d);
    chk("R7 rcfg written, bit4 and 7:6 ignore writes", d, 8'h04);
    top_swap_strap = 1'b1;
    repeat (2) @(negedge clk);
    rd(OFS, d);
    chk("R7 bit4 follows strap", d, 8'h14);
    top_swap_strap = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_permit_sweep();
    for (int c = 0; c < 16; c++) begin
      logic w, p, l, s;
      {l, p, w, s} = c[3:0];
      do_reset();
      smm_active = s;
      wr(OFS, {2'b00, p, 1'b0, 2'b10, l, 1'b0});
      wr(OFS, {2'b00, p, 1'b0, 2'b10, l, w});
      @(negedge clk);
      chk($sformatf("R8 permit wen=%0b prot=%0b lock=%0b smm=%0b", w, p, l, s),
          {7'b0, flash_wr_ok}, {7'b0, exp_ok(w, p, l, s)});
    end
    // permit follows smm_active one cycle later
    smm_active = 1'b1;
    @(negedge clk);
    smm_active = 1'b0;
    @(negedge clk);
    chk("R8 permit tracks smm drop", {7'b0, flash_wr_ok}, 8'h00);
  endtask

  initial begin
    t_reset_state();
    t_offset();
    t_prot_sticky();
    t_lock_sticky();
    t_smi();
    t_fields();
    t_permit_sweep();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule